// File: doc/BRIEF.md
# Spill-Receive Role Selector

This block sits beside one private L2 slice and decides, set by set, whether the slice pushes its victims out to a neighbouring slice or takes in victims that neighbours push to it. Two small groups of sample sets have fixed roles. One group always spills. The other always receives. Every miss in a sample set moves a shared saturating counter. Misses in spill samples move it up, and misses in receive samples move it down. The counter's top bit sets the role of all the remaining (follower) sets.

The cache raises `miss_valid` with the set index on each miss. It presents each eviction on `evict_valid` with the set index, and it reads back `evict_spill` in the same cycle to decide whether the victim leaves for a neighbour or is dropped. An incoming spilled line is offered on `rx_valid` with its target set. In the same cycle the block answers with exactly one of `rx_ready` (accepted) or `rx_reject` (refused). The block never stalls a sender. A refused line is not held, and the transport must take it elsewhere. All decisions are combinational from the inputs and the registered counter.

Top module: `spill_role_sel`

## Requirements
- R1: A set index is split into an upper half `hi` and a lower half `lo` of SET_W/2 bits each. The set is a spill sample when hi == lo, a receive sample when hi == ~lo, and a follower otherwise. With the default 10 bits, this gives 32 sets in each sample group out of 1024.
- R2: For a spill sample set, `evict_spill` is 1 on an eviction and an incoming line gets `rx_reject`, whatever the counter holds.
- R3: For a receive sample set, `evict_spill` is 0 on an eviction and an incoming line gets `rx_ready`, whatever the counter holds.
- R4: For a follower set, the slice behaves as a spiller (`evict_spill`=1, `rx_reject`) when `role_recv` is 0, and as a receiver (`evict_spill`=0, `rx_ready`) when `role_recv` is 1.
- R5: A miss in a spill sample raises the counter by one, and a miss in a receive sample lowers it by one. A miss in a follower set leaves the counter unchanged. `role_recv` equals the counter's top bit and reflects a miss from the first clock edge after it.
- R6: The counter saturates at 0 and at 2^CNT_W-1 (1023 by default) and does not wrap.
- R7: Reset loads the counter with 2^(CNT_W-1)-1 (511), so `role_recv` is 0 and followers start as spillers.
- R8: While `rx_valid` is 1, exactly one of `rx_ready` and `rx_reject` is 1 in that same cycle. With `rx_valid` at 0 both are 0. With `evict_valid` at 0, `evict_spill` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss happened this cycle |
| miss_set | input | SET_W | Set index of the miss |
| evict_valid | input | 1 | An eviction is being decided this cycle |
| evict_set | input | SET_W | Set index of the eviction |
| evict_spill | output | 1 | Send the victim to a neighbour slice |
| rx_valid | input | 1 | An incoming spilled line is offered |
| rx_set | input | SET_W | Target set of the incoming line |
| rx_ready | output | 1 | Incoming line accepted |
| rx_reject | output | 1 | Incoming line refused |
| role_recv | output | 1 | Follower role: 1 receive, 0 spill |

## Verification
The eviction and receive answers are due in the same cycle as their inputs. The bench drives them after a falling edge and samples a nanosecond later, before the next rising edge. A miss takes effect on the one rising edge that follows it. The bench therefore holds each miss for one cycle and reads `role_recv` after the next falling edge, when exactly one counter update has happened. The bench's arithmetic model of the counter predicts the role at every such point. Full sweeps over all set indices, in both roles, cover the sample-set hash.

// File: rtl/spill_role_pkg.sv
package spill_role_pkg;
  typedef enum logic [1:0] {
    KIND_FOLLOW     = 2'd0,
    KIND_LEAD_SPILL = 2'd1,
    KIND_LEAD_RECV  = 2'd2
  } set_kind_e;
endpackage

// File: rtl/spill_set_classify.sv
module spill_set_classify
  import spill_role_pkg::*;
#(
  parameter int SET_W = 10
) (
  input  logic [SET_W-1:0] set_idx,
  output set_kind_e        kind
);
  localparam int HALF = SET_W / 2;

  logic [HALF-1:0] hi_part;
  logic [HALF-1:0] lo_part;

  assign hi_part = set_idx[SET_W-1 -: HALF];
  assign lo_part = set_idx[HALF-1:0];

  always_comb begin
    if (hi_part == lo_part)       kind = KIND_LEAD_SPILL;
    else if (hi_part == ~lo_part) kind = KIND_LEAD_RECV;
    else                          kind = KIND_FOLLOW;
  end
endmodule

// File: rtl/spill_duel_counter.sv
module spill_duel_counter #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic down,
  output logic top_bit
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_INIT = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
    end else if (up && !down && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (down && !up && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_bit = cnt_q[CNT_W-1];
endmodule

// File: rtl/spill_role_sel.sv
module spill_role_sel
  import spill_role_pkg::*;
#(
  parameter int SET_W = 10,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [SET_W-1:0] miss_set,
  input  logic             evict_valid,
  input  logic [SET_W-1:0] evict_set,
  output logic             evict_spill,
  input  logic             rx_valid,
  input  logic [SET_W-1:0] rx_set,
  output logic             rx_ready,
  output logic             rx_reject,
  output logic             role_recv
);
  localparam int LANES = 3;
  localparam int L_MISS = 0;
  localparam int L_EVICT = 1;
  localparam int L_RX = 2;

  logic [SET_W-1:0] lane_set  [LANES];
  set_kind_e        lane_kind [LANES];
  logic             lane_spill[LANES];

  assign lane_set[L_MISS]  = miss_set;
  assign lane_set[L_EVICT] = evict_set;
  assign lane_set[L_RX]    = rx_set;

  logic follower_recv;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    spill_set_classify #(.SET_W(SET_W)) u_cls (
      .set_idx (lane_set[g]),
      .kind    (lane_kind[g])
    );
    always_comb begin
      unique case (lane_kind[g])
        KIND_LEAD_SPILL: lane_spill[g] = 1'b1;
        KIND_LEAD_RECV:  lane_spill[g] = 1'b0;
        default:         lane_spill[g] = !follower_recv;
      endcase
    end
  end

  logic cnt_up;
  logic cnt_down;

  assign cnt_up   = miss_valid && (lane_kind[L_MISS] == KIND_LEAD_SPILL);
  assign cnt_down = miss_valid && (lane_kind[L_MISS] == KIND_LEAD_RECV);

  spill_duel_counter #(.CNT_W(CNT_W)) u_duel (
    .clk     (clk),
    .rst_n   (rst_n),
    .up      (cnt_up),
    .down    (cnt_down),
    .top_bit (follower_recv)
  );

  assign role_recv   = follower_recv;
  assign evict_spill = evict_valid && lane_spill[L_EVICT];
  assign rx_reject   = rx_valid && lane_spill[L_RX];
  assign rx_ready    = rx_valid && !lane_spill[L_RX];
endmodule

// File: rtl/spill_role_sel_chk.sv
module spill_role_sel_chk (
  input logic clk,
  input logic rst_n,
  input logic miss_valid,
  input logic evict_valid,
  input logic evict_spill,
  input logic rx_valid,
  input logic rx_ready,
  input logic rx_reject,
  input logic role_recv
);
  // R8: one answer per offered line
  p_rx_one_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_ready ^ rx_reject));

  // R8: silent when nothing is offered
  p_rx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (!rx_ready && !rx_reject));

  // R8: no spill without an eviction
  p_evict_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_valid |-> !evict_spill);

  // R5: role holds across a cycle with no miss
  p_role_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |=> $stable(role_recv));

  // R5: a role change is always caused by a miss
  p_role_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(role_recv) || $fell(role_recv)) |-> $past(miss_valid));
endmodule

bind spill_role_sel spill_role_sel_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .miss_valid  (miss_valid),
  .evict_valid (evict_valid),
  .evict_spill (evict_spill),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_reject   (rx_reject),
  .role_recv   (role_recv)
);

// File: tb/spill_role_sel_test.sv
`timescale 1ns/1ps
module spill_role_sel_test;
  localparam int SET_W = 10;
  localparam int CNT_W = 10;
  localparam int HALF  = SET_W / 2;
  localparam int NSETS = 1 << SET_W;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [SET_W-1:0] miss_set = '0;
  logic evict_valid = 1'b0;
  logic [SET_W-1:0] evict_set = '0;
  logic evict_spill;
  logic rx_valid = 1'b0;
  logic [SET_W-1:0] rx_set = '0;
  logic rx_ready;
  logic rx_reject;
  logic role_recv;

  int n_checks = 0;
  int n_fails = 0;
  int model_cnt = (1 << (CNT_W - 1)) - 1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spill_role_sel #(.SET_W(SET_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_set(miss_set),
    .evict_valid(evict_valid), .evict_set(evict_set), .evict_spill(evict_spill),
    .rx_valid(rx_valid), .rx_set(rx_set), .rx_ready(rx_ready), .rx_reject(rx_reject),
    .role_recv(role_recv)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 follower, 1 spill sample, 2 receive sample (R1)
  function automatic int kind_of(input int s);
    int hi = s >> HALF;
    int lo = s & ((1 << HALF) - 1);
    if (hi == lo) return 1;
    if (hi == (((1 << HALF) - 1) - lo)) return 2;
    return 0;
  endfunction

  function automatic int exp_role();
    return (model_cnt >> (CNT_W - 1)) & 1;
  endfunction

  task automatic do_miss(input int s, input string req);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_set = s[SET_W-1:0];
    if (kind_of(s) == 1 && model_cnt < CMAX) model_cnt++;
    else if (kind_of(s) == 2 && model_cnt > 0) model_cnt--;
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
    check(role_recv == exp_role(), req, role_recv, exp_role());
  endtask

  task automatic sweep();
    for (int s = 0; s < NSETS; s++) begin
      int k = kind_of(s);
      int sp = (k == 1) ? 1 : (k == 2) ? 0 : (1 - exp_role());
      string req = (k == 1) ? "R2 R1" : (k == 2) ? "R3 R1" : "R4 R1";
      @(negedge clk);
      evict_valid = 1'b1; evict_set = s[SET_W-1:0];
      rx_valid = 1'b1;    rx_set = s[SET_W-1:0];
      #1;
      check(evict_spill == sp, req, evict_spill, sp);
      check(rx_ready == !sp && rx_reject == sp, {req, " R8"}, {rx_ready, rx_reject}, {!sp[0], sp[0]});
    end
    @(negedge clk);
    evict_valid = 1'b0; rx_valid = 1'b0;
    #1;
    check(!evict_spill && !rx_ready && !rx_reject, "R8 idle", {evict_spill, rx_ready, rx_reject}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(role_recv == 1'b0, "R7 reset role", role_recv, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(role_recv == 1'b0, "R7 after release", role_recv, 0);

    sweep();                                  // followers spill
    do_miss(1, "R5 follower miss ignored");
    do_miss(0, "R5 spill sample miss");       // 512: receiver
    check(role_recv == 1'b1, "R5 role flips", role_recv, 1);
    sweep();                                  // followers receive
    do_miss(31, "R5 receive sample miss");    // back to 511
    do_miss(2, "R5 follower miss ignored");

    for (int i = 0; i < 600; i++) do_miss(((i % 32) << HALF) | (i % 32), "R5 R6 climb");
    for (int i = 0; i < 511; i++) do_miss((((i % 32) << HALF) | (31 - (i % 32))), "R6 top saturation");
    check(role_recv == 1'b1, "R6 top saturation", role_recv, 1);
    do_miss(31, "R6 top crossing");
    check(role_recv == 1'b0, "R6 top crossing", role_recv, 0);

    for (int i = 0; i < 600; i++) do_miss((((i % 32) << HALF) | (31 - (i % 32))), "R5 R6 descend");
    for (int i = 0; i < 511; i++) do_miss(((i % 32) << HALF) | (i % 32), "R6 bottom saturation");
    check(role_recv == 1'b0, "R6 bottom saturation", role_recv, 0);
    do_miss(0, "R6 bottom crossing");
    check(role_recv == 1'b1, "R6 bottom crossing", role_recv, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule